// File: doc/BRIEF.md
# Bus Controller Message-Instruction Sequencer

This block walks an instruction list held in a word-wide synchronous RAM on behalf of a MIL-STD-1553 bus controller. Each message instruction is two words: an opcode, then the RAM address of a message control/status block. The sequencer reads both words, fetches the time-to-next-message word from the block, waits until any running inter-message countdown has expired, starts the message engine and loads the countdown. When the engine reports completion with a true condition code, the sequencer rewrites the list's parameter word with the block address with bit 4 inverted. The list therefore alternates between two blocks from one pass to the next.

Two message opcodes differ only in how they pace the list. The waiting form does not fetch the following opcode until the countdown is zero. The going form moves on at once, so instructions that send no message run while the countdown continues. Either form, when it is reached, still holds back its own message start until the countdown is zero. A one-word no-operation opcode stands in for the other non-message instructions. Any other word halts the sequencer and raises an error flag. The countdown can be read through a small register view.

Top module: `bcx_msg_sequencer`

## Requirements
- R1: The opcode is the full 16-bit word. 0x0015 is the waiting message form, 0x001A is the going message form, and 0x0000 is a one-word no-op. Any other value raises `err_halt`. After that, no message is started and no RAM write is issued.
- R2: The word after a message opcode is the block address. `msg_blk_addr` carries that value while `msg_start` is high.
- R3: On completion with `cond_code` high, the value block address XOR 0x0010 is written to the parameter word (opcode address + 1). A write happens only in the cycle after such a completion.
- R4: On completion with `cond_code` low, the parameter word is left unchanged.
- R5: At message start, the word at block address + 3 is loaded into the countdown when it is nonzero. A zero word leaves the countdown as it was.
- R6: The countdown decreases by one on each cycle with `tick_1us` high and stops at zero. It holds its value when `tick_1us` is low.
- R7: After a 0x0015 message completes, the next opcode is not fetched until the countdown reads zero.
- R8: After a 0x001A message completes, the next opcode is fetched without waiting. A following no-op runs while the countdown is still nonzero.
- R9: `msg_start` is never raised while the countdown is nonzero.
- R10: Register address 0x36 reads the countdown on `reg_rdata`. Every other register address reads zero.
- R11: During reset, `msg_start`, `mem_we` and `err_halt` are low and the countdown reads zero. Execution starts at list address 0.
- R12: `msg_start` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | Countdown tick enable |
| mem_addr | output | ADDR_W | RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, one cycle after address |
| msg_start | output | 1 | Message engine start pulse |
| msg_blk_addr | output | ADDR_W | Control/status block address of the current message |
| msg_done | input | 1 | Message engine completion pulse |
| cond_code | input | 1 | Condition code, sampled with `msg_done` |
| reg_addr | input | REG_AW | Register view address |
| reg_rdata | output | 16 | Register view data |
| err_halt | output | 1 | Unknown opcode, sequencer halted |

## Verification
The bench builds the block with an 8-bit list address, so a 256-word RAM model in the bench holds the whole address space, and with the default 16-bit countdown. It sweeps both message opcodes against both condition outcomes and against countdown words of 0, 1, 5 and 40. The value 40 outlasts the message engine's latency, so it separates the waiting form from the going form at the point where the no-op is fetched. A further run holds the tick low to show the countdown freezing and the second message being held back, then releases it.

// File: rtl/bcx_pkg.sv
package bcx_pkg;

  localparam int WORD_W = 16;

  localparam logic [WORD_W-1:0] OPC_MSG_WAIT = 16'h0015;
  localparam logic [WORD_W-1:0] OPC_MSG_GO   = 16'h001A;
  localparam logic [WORD_W-1:0] OPC_NOP      = 16'h0000;

  typedef enum logic [3:0] {
    ST_FETCH_OP,
    ST_FETCH_PARAM,
    ST_READ_TIMER,
    ST_START_MSG,
    ST_WAIT_DONE,
    ST_WRITEBACK,
    ST_WAIT_TIMER,
    ST_NEXT,
    ST_HALT
  } seq_state_e;

endpackage

// File: rtl/bcx_rst_sync.sv
module bcx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/bcx_ttn_timer.sv
module bcx_ttn_timer #(
  parameter int TTN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TTN_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [TTN_W-1:0] count_o,
  output logic             zero_o
);

  logic [TTN_W-1:0] cnt_q;
  logic [TTN_W-1:0] cnt_d;
  logic             cnt_en;
  logic             load_nz;

  assign load_nz = load_i && (load_val_i != '0);
  assign zero_o  = (cnt_q == '0);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_nz) begin
      cnt_en = 1'b1;
      cnt_d  = load_val_i;
    end else if (tick_i && !zero_o) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - TTN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/bcx_seq_fsm.sv
module bcx_seq_fsm
  import bcx_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int TTN_W         = 16,
  parameter int FLIP_BIT      = 4,
  parameter int TTN_WORD_OFFS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              msg_start,
  output logic [ADDR_W-1:0] msg_blk_addr,
  input  logic              msg_done,
  input  logic              cond_code,
  input  logic              timer_zero,
  output logic              timer_load,
  output logic [TTN_W-1:0]  timer_load_val,
  output logic              err_halt
);

  localparam logic [ADDR_W-1:0] FLIP_MASK = ADDR_W'(1) << FLIP_BIT;
  localparam logic [ADDR_W-1:0] TTN_OFFS  = ADDR_W'(TTN_WORD_OFFS);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] ip_q, ip_d;
  logic [ADDR_W-1:0] blk_q, blk_d;
  logic              wait_var_q, wait_var_d;
  logic              two_word_q, two_word_d;
  logic              regs_en;

  // next-state and datapath decisions
  always_comb begin
    state_d    = state_q;
    ip_d       = ip_q;
    blk_d      = blk_q;
    wait_var_d = wait_var_q;
    two_word_d = two_word_q;
    msg_start  = 1'b0;
    timer_load = 1'b0;
    mem_we     = 1'b0;
    unique case (state_q)
      ST_FETCH_OP: state_d = ST_FETCH_PARAM;
      ST_FETCH_PARAM: begin
        if (mem_rdata == OPC_MSG_WAIT) begin
          wait_var_d = 1'b1;
          two_word_d = 1'b1;
          state_d    = ST_READ_TIMER;
        end else if (mem_rdata == OPC_MSG_GO) begin
          wait_var_d = 1'b0;
          two_word_d = 1'b1;
          state_d    = ST_READ_TIMER;
        end else if (mem_rdata == OPC_NOP) begin
          two_word_d = 1'b0;
          state_d    = ST_NEXT;
        end else begin
          state_d = ST_HALT;
        end
      end
      ST_READ_TIMER: begin
        blk_d   = mem_rdata[ADDR_W-1:0];
        state_d = ST_START_MSG;
      end
      ST_START_MSG: begin
        if (timer_zero) begin
          msg_start  = 1'b1;
          timer_load = 1'b1;
          state_d    = ST_WAIT_DONE;
        end
      end
      ST_WAIT_DONE: begin
        if (msg_done) begin
          if (cond_code)       state_d = ST_WRITEBACK;
          else if (wait_var_q) state_d = ST_WAIT_TIMER;
          else                 state_d = ST_NEXT;
        end
      end
      ST_WRITEBACK: begin
        mem_we  = 1'b1;
        state_d = wait_var_q ? ST_WAIT_TIMER : ST_NEXT;
      end
      ST_WAIT_TIMER: begin
        if (timer_zero) state_d = ST_NEXT;
      end
      ST_NEXT: begin
        ip_d    = ip_q + (two_word_q ? ADDR_W'(2) : ADDR_W'(1));
        state_d = ST_FETCH_OP;
      end
      default: state_d = ST_HALT;
    endcase
  end

  // RAM address selection by phase
  always_comb begin
    unique case (state_q)
      ST_FETCH_PARAM, ST_WRITEBACK: mem_addr = ip_q + ADDR_W'(1);
      ST_READ_TIMER:                mem_addr = mem_rdata[ADDR_W-1:0] + TTN_OFFS;
      ST_START_MSG:                 mem_addr = blk_q + TTN_OFFS;
      default:                      mem_addr = ip_q;
    endcase
  end

  assign regs_en = (state_q != ST_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_FETCH_OP;
      ip_q       <= '0;
      blk_q      <= '0;
      wait_var_q <= 1'b0;
      two_word_q <= 1'b0;
    end else if (regs_en) begin
      state_q    <= state_d;
      ip_q       <= ip_d;
      blk_q      <= blk_d;
      wait_var_q <= wait_var_d;
      two_word_q <= two_word_d;
    end
  end

  assign mem_wdata      = WORD_W'(blk_q ^ FLIP_MASK);
  assign msg_blk_addr   = blk_q;
  assign timer_load_val = mem_rdata[TTN_W-1:0];
  assign err_halt       = (state_q == ST_HALT);

endmodule

// File: rtl/bcx_msg_sequencer.sv
module bcx_msg_sequencer
  import bcx_pkg::*;
#(
  parameter int               ADDR_W        = 16,
  parameter int               TTN_W         = 16,
  parameter int               REG_AW        = 8,
  parameter logic [REG_AW-1:0] TTN_REG_ADDR = 8'h36,
  parameter int               FLIP_BIT      = 4,
  parameter int               TTN_WORD_OFFS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1us,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              msg_start,
  output logic [ADDR_W-1:0] msg_blk_addr,
  input  logic              msg_done,
  input  logic              cond_code,
  input  logic [REG_AW-1:0] reg_addr,
  output logic [15:0]       reg_rdata,
  output logic              err_halt
);

  logic             rst_n_int;
  logic             timer_zero;
  logic             timer_load;
  logic [TTN_W-1:0] timer_load_val;
  logic [TTN_W-1:0] ttn_cnt;

  bcx_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  bcx_seq_fsm #(
    .ADDR_W        (ADDR_W),
    .TTN_W         (TTN_W),
    .FLIP_BIT      (FLIP_BIT),
    .TTN_WORD_OFFS (TTN_WORD_OFFS)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .mem_addr       (mem_addr),
    .mem_we         (mem_we),
    .mem_wdata      (mem_wdata),
    .mem_rdata      (mem_rdata),
    .msg_start      (msg_start),
    .msg_blk_addr   (msg_blk_addr),
    .msg_done       (msg_done),
    .cond_code      (cond_code),
    .timer_zero     (timer_zero),
    .timer_load     (timer_load),
    .timer_load_val (timer_load_val),
    .err_halt       (err_halt)
  );

  bcx_ttn_timer #(
    .TTN_W (TTN_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .load_i     (timer_load),
    .load_val_i (timer_load_val),
    .tick_i     (tick_1us),
    .count_o    (ttn_cnt),
    .zero_o     (timer_zero)
  );

  always_comb begin
    if (reg_addr == TTN_REG_ADDR) reg_rdata = WORD_W'(ttn_cnt);
    else                          reg_rdata = '0;
  end

endmodule

// File: rtl/bcx_msg_sequencer_chk.sv
module bcx_msg_sequencer_chk #(
  parameter int TTN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_1us,
  input logic             msg_start,
  input logic             msg_done,
  input logic             cond_code,
  input logic             mem_we,
  input logic             err_halt,
  input logic [TTN_W-1:0] ttn_cnt
);

  AST_WB_AFTER_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(msg_done && cond_code)); // R3

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start |-> (ttn_cnt == '0)); // R9

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start |=> !msg_start); // R12

  AST_TTN_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_start && tick_1us && (ttn_cnt != '0)) |=> (ttn_cnt == $past(ttn_cnt) - TTN_W'(1))); // R6

  AST_TTN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_start && !tick_1us) |=> $stable(ttn_cnt)); // R6

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_halt |=> (err_halt && !msg_start && !mem_we)); // R1

endmodule

bind bcx_msg_sequencer bcx_msg_sequencer_chk #(.TTN_W(TTN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_1us  (tick_1us),
  .msg_start (msg_start),
  .msg_done  (msg_done),
  .cond_code (cond_code),
  .mem_we    (mem_we),
  .err_halt  (err_halt),
  .ttn_cnt   (ttn_cnt)
);

// File: tb/test_bcx_msg_sequencer.sv
module test_bcx_msg_sequencer;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_1us = 1'b1;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [15:0]   mem_wdata;
  logic [15:0]   mem_rdata = '0;
  logic          msg_start;
  logic [AW-1:0] msg_blk_addr;
  logic          msg_done = 1'b0;
  logic          cond_code = 1'b0;
  logic [7:0]    reg_addr = 8'h36;
  logic [15:0]   reg_rdata;
  logic          err_halt;

  always #2.5 clk = ~clk;

  bcx_msg_sequencer #(.ADDR_W(AW)) i_bcx_msg_sequencer (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .msg_start(msg_start), .msg_blk_addr(msg_blk_addr), .msg_done(msg_done),
    .cond_code(cond_code), .reg_addr(reg_addr), .reg_rdata(reg_rdata), .err_halt(err_halt)
  );

  logic [15:0] ram [0:255];

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  int eng_cnt = 0;
  always @(posedge clk) begin
    msg_done <= 1'b0;
    if (eng_cnt != 0) begin
      eng_cnt <= eng_cnt - 1;
      if (eng_cnt == 1) msg_done <= 1'b1;
    end else if (msg_start) begin
      eng_cnt <= 3;
    end
  end

  int n_chk = 0, n_fail = 0;
  int cyc = 0, n_starts = 0, s1 = 0, s2 = 0;
  int blk1 = 0, blk2 = 0, ttn_after = -1, nop_timer = -1;
  bit grab = 0, prev_start = 0, dbl = 0, nop_seen = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (grab) begin
        ttn_after = reg_rdata;
        grab = 0;
      end
      if (prev_start && msg_start) dbl = 1;
      if (msg_start) begin
        n_starts++;
        if (n_starts == 1) begin
          s1 = cyc; blk1 = msg_blk_addr; grab = 1;
        end else begin
          s2 = cyc; blk2 = msg_blk_addr;
        end
      end
      if (!nop_seen && mem_addr == 8'd2) begin
        nop_seen = 1;
        nop_timer = reg_rdata;
      end
      prev_start = msg_start;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic [15:0] op, input bit cnd, input int t, input bit tk);
    @(negedge clk);
    rst_n = 1'b0;
    tick_1us = tk;
    cond_code = cnd;
    reg_addr = 8'h36;
    for (int i = 0; i < 256; i++) ram[i] = 16'h0000;
    ram[0] = op;    ram[1] = 16'h0040;
    ram[2] = 16'h0000;
    ram[3] = 16'h0015; ram[4] = 16'h0080;
    ram[5] = 16'h00FF;
    ram[8'h43] = 16'(t);
    ram[8'h83] = 16'd7;
    repeat (4) @(negedge clk);
    chk(msg_start == 0 && mem_we == 0 && err_halt == 0, "R11 outputs in reset", int'(msg_start) + int'(mem_we) + int'(err_halt), 0);
    chk(reg_rdata == 0, "R11 countdown in reset", reg_rdata, 0);
    n_starts = 0; grab = 0; prev_start = 0; dbl = 0; nop_seen = 0;
    ttn_after = -1; nop_timer = -1; s1 = 0; s2 = 0;
    rst_n = 1'b1;
  endtask

  task automatic wait_halt();
    int n = 0;
    while (!err_halt && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(err_halt == 1, "R1 watchdog / halt on unknown opcode", err_halt, 1);
    repeat (20) @(negedge clk);
  endtask

  task automatic run_case(input logic [15:0] op, input bit cnd, input int t);
    setup(op, cnd, t, 1'b1);
    wait_halt();
    chk(n_starts == 2, "R1 two messages then halt", n_starts, 2);
    chk(ram[1] == (cnd ? 16'h0050 : 16'h0040), cnd ? "R3 first parameter flipped" : "R4 first parameter kept", ram[1], cnd ? 16'h50 : 16'h40);
    chk(ram[4] == (cnd ? 16'h0090 : 16'h0080), cnd ? "R3 second parameter flipped" : "R4 second parameter kept", ram[4], cnd ? 16'h90 : 16'h80);
    chk(blk1 == 16'h40 && blk2 == 16'h80, "R2 block address at start", blk1 * 256 + blk2, 16'h4080);
    chk(ttn_after == t, "R5 countdown loaded at start", ttn_after, t);
    chk(s2 - s1 >= t, "R9 second start held by countdown", s2 - s1, t);
    chk(!dbl, "R12 start is one cycle", dbl, 0);
    if (op == 16'h0015) chk(nop_timer == 0, "R7 fetch waits for zero", nop_timer, 0);
    if (op == 16'h001A && t == 40) chk(nop_timer > 0, "R8 no-op runs during countdown", nop_timer, 1);
    chk(reg_rdata == 0, "R6 countdown stops at zero", reg_rdata, 0);
    reg_addr = 8'h35;
    #1;
    chk(reg_rdata == 0, "R10 other register reads zero", reg_rdata, 0);
    reg_addr = 8'h36;
  endtask

  initial begin
    int n;
    for (int o = 0; o < 2; o++)
      for (int c = 0; c < 2; c++)
        for (int k = 0; k < 4; k++)
          run_case(o == 0 ? 16'h0015 : 16'h001A, c[0], (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 5 : 40);

    // tick held low: countdown freezes, next message held back
    setup(16'h001A, 1'b1, 5, 1'b0);
    n = 0;
    while (n_starts < 1 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (30) @(negedge clk);
    chk(reg_rdata == 5, "R6 countdown holds without tick", reg_rdata, 5);
    chk(n_starts == 1, "R9 no start while countdown nonzero", n_starts, 1);
    chk(ram[1] == 16'h0050, "R3 flip written while go form waits", ram[1], 16'h50);
    tick_1us = 1'b1;
    wait_halt();
    chk(n_starts == 2, "R8 second message after release", n_starts, 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule